// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block decides the operating mode of a LIN slave transceiver that carries its own supply regulator. It takes digitized comparator flags for the battery supply, a flag for undervoltage on the regulated rail, the enable and transmit pins from the host, the sampled bus level and a local wake request. From these inputs it drives the regulator enable, the transceiver enable, the receive-data level seen by the host, and an active-low reset for the host.

The core is a five-state machine: Unpowered, Fail-safe, Normal, Silent and Sleep. The host chooses between Silent and Sleep by the level of TXD at the moment EN goes low. A filter watches the bus in the two low-power modes. It accepts a wake-up only after the bus has stayed dominant for an unbroken window. A hold-off timer keeps the host reset asserted for a fixed time after the rail recovers. All timing counts a shared clock-enable tick. A parameter gives the number of ticks per microsecond, and the two windows are set in microseconds.

Top module: `lin_mode_ctrl`

## Requirements
- R1: While rst_n is low and on the first cycle after reset, mode_o is Unpowered (code 0) and reg_en_o, xcvr_en_o, rxd_o and nres_o are all 0. The mode codes are Unpowered=0, Fail-safe=1, Normal=2, Silent=3, Sleep=4.
- R2: Unpowered moves to Fail-safe on the clock after vs_hi_i is 1. From any other mode, vs_lo_i at 1 returns the block to Unpowered on the next clock, and this takes priority over every other transition.
- R3: EN high in Fail-safe or Silent enters Normal on the next clock. In Normal, rxd_o follows bus_i combinationally, with 1 meaning recessive.
- R4: In Normal, EN low moves to Silent on the next clock if txd_i is 1 in that cycle, and to Sleep if txd_i is 0.
- R5: In Silent or Sleep, a bus wake-up moves the block to Fail-safe. A wake-up is WAKE_US*TICKS_PER_US ticks counted while bus_i stays 0 without a break. Any sample of bus_i at 1 restarts the count.
- R6: In Sleep, EN high leads to Normal only if a local_wake_i pulse has been seen since Sleep was entered, or is present in the same cycle. Without one, Sleep is held.
- R7: nres_o goes to 0 on the clock after vcc_uv_i is 1 or the regulator is off. It returns to 1 only after RESET_US*TICKS_PER_US ticks with the rail good and the regulator on.
- R8: In Silent, nres_o at 0 moves the block to Fail-safe on the next clock.
- R9: rxd_o is 1 in Silent and 0 in Sleep and Unpowered. In Fail-safe it is 1, except after a bus wake-up, when it stays 0 until Fail-safe is left.
- R10: reg_en_o is 1 in Fail-safe, Normal and Silent and 0 otherwise. xcvr_en_o is 1 only in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Timing clock-enable tick |
| vs_hi_i | input | 1 | Battery supply above the power-up threshold |
| vs_lo_i | input | 1 | Battery supply below the power-down threshold |
| vcc_uv_i | input | 1 | Regulated rail below its undervoltage threshold |
| en_i | input | 1 | Host enable pin |
| txd_i | input | 1 | Host transmit pin |
| bus_i | input | 1 | Sampled bus level, 1 = recessive |
| local_wake_i | input | 1 | Local wake-up request |
| mode_o | output | 3 | Current mode code |
| reg_en_o | output | 1 | Regulator enable |
| xcvr_en_o | output | 1 | Transceiver (TXD-to-bus, bus-to-RXD) enable |
| rxd_o | output | 1 | Receive data level to host |
| nres_o | output | 1 | Active-low host reset |

## Verification
The bench breaks a dominant bus into bursts that together run longer than the wake window, but each burst stays shorter than the window. A filter that accumulated across recessive samples would wake up falsely and leave Silent. It raises EN in Sleep without a local wake to show that Sleep is held, and a controller that treated Sleep like Silent would jump straight to Normal. It also checks that the receive line stays low in Fail-safe after a bus wake-up, which a design without that marker would drive high. It checks that a rail undervoltage in Silent passes through the reset output into Fail-safe, which a design that ignored the reset in Silent would never leave.

// File: rtl/lin_mode_pkg.sv
// Shared mode encoding for the LIN mode controller.
// The code values are visible at the top-level mode output.
package lin_mode_pkg;

    typedef enum logic [2:0] {
        M_UNPWR    = 3'd0,
        M_FAILSAFE = 3'd1,
        M_NORMAL   = 3'd2,
        M_SILENT   = 3'd3,
        M_SLEEP    = 3'd4
    } lin_mode_e;

endpackage

// File: rtl/lin_wake_filter.sv
// Bus wake-up filter.
// While armed, it counts ticks during which the bus stays dominant (bus_i == 0).
// Any recessive sample, or dropping arm, clears the count.
// wake_o is high while armed and the count has reached LIMIT.
// Assumes that tick_i is a single-cycle clock enable.
module lin_wake_filter #(
    parameter int LIMIT = 1440
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic bus_i,
    output logic wake_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count dominant ticks, saturating at the limit; restart on recessive.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_i || bus_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Report a qualified wake-up only while armed.
    assign wake_o = arm_i && (cnt_q == LIM);

    // R5: a recessive sample while armed leaves the count empty.
    p_clear_recessive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && bus_i) |=> (cnt_q == '0));

    // R5: a wake-up only starts after a dominant bus sample.
    p_wake_dominant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(!bus_i));

endmodule

// File: rtl/lin_reset_timer.sv
// Host reset hold-off timer.
// nres_o drops on the clock after the rail is reported bad.
// It rises only after LIMIT ticks of a good rail.
// Assumes that vcc_ok_i already combines the regulator enable with the undervoltage flag.
module lin_reset_timer #(
    parameter int LIMIT = 64000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic vcc_ok_i,
    output logic nres_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;
    logic          nres_q;

    // Hold reset while the rail is bad; release it after the hold-off count.
    always_ff @(posedge clk) begin
        if (!rst_n || !vcc_ok_i) begin
            cnt_q  <= '0;
            nres_q <= 1'b0;
        end else if (cnt_q == LIM) begin
            nres_q <= 1'b1;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign nres_o = nres_q;

    // R7: a bad rail forces the reset low on the next clock.
    p_nres_low_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_ok_i |=> !nres_o);

    // R7: the reset is only released while the rail has been good.
    p_nres_rise_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nres_o) |-> $past(vcc_ok_i));

endmodule

// File: rtl/lin_mode_fsm.sv
// Operating-mode state machine.
// Selects Unpowered, Fail-safe, Normal, Silent or Sleep from the supply flags,
// the host pins, the wake sources and the host reset.
// It also derives the enables and the receive-data level from the mode.
// Assumes that bus_wake_i comes from a filter armed by arm_o.
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      vs_hi_i,
    input  logic      vs_lo_i,
    input  logic      en_i,
    input  logic      txd_i,
    input  logic      bus_i,
    input  logic      local_wake_i,
    input  logic      bus_wake_i,
    input  logic      nres_i,
    output lin_mode_e mode_o,
    output logic      arm_o,
    output logic      reg_en_o,
    output logic      xcvr_en_o,
    output logic      rxd_o
);
    lin_mode_e mode_q, mode_d;
    logic      lwp_q;
    logic      wflag_q;

    // Next-mode selection; a supply drop overrides every other request.
    always_comb begin
        mode_d = mode_q;
        if (mode_q != M_UNPWR && vs_lo_i) begin
            mode_d = M_UNPWR;
        end else begin
            case (mode_q)
                M_UNPWR:    if (vs_hi_i) mode_d = M_FAILSAFE;
                M_FAILSAFE: if (en_i) mode_d = M_NORMAL;
                M_NORMAL:   if (!en_i) mode_d = txd_i ? M_SILENT : M_SLEEP;
                M_SILENT: begin
                    if (bus_wake_i || !nres_i) mode_d = M_FAILSAFE;
                    else if (en_i)             mode_d = M_NORMAL;
                end
                M_SLEEP: begin
                    if (bus_wake_i)                            mode_d = M_FAILSAFE;
                    else if (en_i && (lwp_q || local_wake_i))  mode_d = M_NORMAL;
                end
                default:    mode_d = M_UNPWR;
            endcase
        end
    end

    // Mode register, local-wake memory and bus-wake marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= M_UNPWR;
            lwp_q   <= 1'b0;
            wflag_q <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            lwp_q   <= (mode_q == M_SLEEP) && mode_d == M_SLEEP && (lwp_q || local_wake_i);
            wflag_q <= (mode_d == M_FAILSAFE) &&
                       ((mode_q == M_FAILSAFE) ? wflag_q : bus_wake_i);
        end
    end

    // Mode-dependent outputs.
    always_comb begin
        reg_en_o  = 1'b0;
        xcvr_en_o = 1'b0;
        rxd_o     = 1'b0;
        case (mode_q)
            M_FAILSAFE: begin reg_en_o = 1'b1; rxd_o = !wflag_q; end
            M_NORMAL:   begin reg_en_o = 1'b1; xcvr_en_o = 1'b1; rxd_o = bus_i; end
            M_SILENT:   begin reg_en_o = 1'b1; rxd_o = 1'b1; end
            default:    ;
        endcase
    end

    assign arm_o  = (mode_q == M_SILENT) || (mode_q == M_SLEEP);
    assign mode_o = mode_q;

    // R2: a supply drop in any powered mode returns to Unpowered.
    p_vs_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (vs_lo_i && mode_q != M_UNPWR) |=> (mode_q == M_UNPWR));

    // R4: the TXD level at EN low selects Silent or Sleep.
    p_normal_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_NORMAL && !en_i && !vs_lo_i)
        |=> (mode_q == ($past(txd_i) ? M_SILENT : M_SLEEP)));

    // R6: without a wake source, Sleep is held.
    p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SLEEP && !vs_lo_i && !bus_wake_i && !lwp_q && !local_wake_i)
        |=> (mode_q == M_SLEEP));

    // R8: a host reset in Silent returns to Fail-safe.
    p_silent_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_SILENT && !nres_i && !vs_lo_i) |=> (mode_q == M_FAILSAFE));

endmodule

// File: rtl/lin_mode_ctrl.sv
// Top level of the LIN transceiver mode controller.
// Connects the mode state machine, the bus wake-up filter and the host reset
// hold-off timer. Both windows are counted in ticks of tick_i.
// Assumes that tick_i arrives TICKS_PER_US times per microsecond.
module lin_mode_ctrl #(
    parameter int TICKS_PER_US = 16,
    parameter int WAKE_US      = 90,
    parameter int RESET_US     = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       vs_hi_i,
    input  logic       vs_lo_i,
    input  logic       vcc_uv_i,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       bus_i,
    input  logic       local_wake_i,
    output logic [2:0] mode_o,
    output logic       reg_en_o,
    output logic       xcvr_en_o,
    output logic       rxd_o,
    output logic       nres_o
);
    import lin_mode_pkg::*;

    localparam int WAKE_TICKS  = WAKE_US * TICKS_PER_US;
    localparam int RESET_TICKS = RESET_US * TICKS_PER_US;

    lin_mode_e mode;
    logic      arm;
    logic      bus_wake;
    logic      nres;
    logic      reg_en;

    lin_wake_filter #(.LIMIT(WAKE_TICKS)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .arm_i  (arm),
        .bus_i  (bus_i),
        .wake_o (bus_wake)
    );

    lin_reset_timer #(.LIMIT(RESET_TICKS)) u_rst (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .vcc_ok_i (reg_en && !vcc_uv_i),
        .nres_o   (nres)
    );

    lin_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vs_hi_i      (vs_hi_i),
        .vs_lo_i      (vs_lo_i),
        .en_i         (en_i),
        .txd_i        (txd_i),
        .bus_i        (bus_i),
        .local_wake_i (local_wake_i),
        .bus_wake_i   (bus_wake),
        .nres_i       (nres),
        .mode_o       (mode),
        .arm_o        (arm),
        .reg_en_o     (reg_en),
        .xcvr_en_o    (xcvr_en_o),
        .rxd_o        (rxd_o)
    );

    assign mode_o   = mode;
    assign reg_en_o = reg_en;
    assign nres_o   = nres;

    // R10: the transceiver is never enabled with the regulator off.
    p_xcvr_needs_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_en_o |-> reg_en_o);

endmodule

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;
    localparam int TPU  = 2;
    localparam int WUS  = 5;
    localparam int RUS  = 20;
    localparam int WT   = WUS * TPU;
    localparam int RT   = RUS * TPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 1'b0;
    logic vs_hi_i = 1'b0, vs_lo_i = 1'b0, vcc_uv_i = 1'b0;
    logic en_i = 1'b0, txd_i = 1'b1, bus_i = 1'b1, local_wake_i = 1'b0;
    logic [2:0] mode_o;
    logic reg_en_o, xcvr_en_o, rxd_o, nres_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lin_mode_ctrl #(.TICKS_PER_US(TPU), .WAKE_US(WUS), .RESET_US(RUS)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .vs_hi_i(vs_hi_i),
        .vs_lo_i(vs_lo_i), .vcc_uv_i(vcc_uv_i), .en_i(en_i), .txd_i(txd_i),
        .bus_i(bus_i), .local_wake_i(local_wake_i), .mode_o(mode_o),
        .reg_en_o(reg_en_o), .xcvr_en_o(xcvr_en_o), .rxd_o(rxd_o), .nres_o(nres_o)
    );

    // Tick generator: one tick every third clock, changed just after the edge.
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick_i = (tdiv == 0);
    end

    // Behavioural reference model, advanced on each rising edge.
    int  m_mode = 0, m_w = 0, m_r = 0;
    bit  m_nres = 0, m_lwp = 0, m_wflag = 0;

    function automatic bit regen(int m);
        return (m == 1 || m == 2 || m == 3);
    endfunction

    always @(posedge clk) begin
        int  nm, nw, nr;
        bit  nn, wk;
        if (!rst_n) begin
            m_mode = 0; m_w = 0; m_r = 0; m_nres = 0; m_lwp = 0; m_wflag = 0;
        end else begin
            wk = (m_mode == 3 || m_mode == 4) && (m_w == WT);
            nm = m_mode;
            if (m_mode != 0 && vs_lo_i) nm = 0;
            else if (m_mode == 0) begin if (vs_hi_i) nm = 1; end
            else if (m_mode == 1) begin if (en_i) nm = 2; end
            else if (m_mode == 2) begin if (!en_i) nm = txd_i ? 3 : 4; end
            else if (m_mode == 3) begin
                if (wk || !m_nres) nm = 1; else if (en_i) nm = 2;
            end else begin
                if (wk) nm = 1; else if (en_i && (m_lwp || local_wake_i)) nm = 2;
            end
            nw = m_w;
            if (!(m_mode == 3 || m_mode == 4) || bus_i) nw = 0;
            else if (tick_i && m_w < WT) nw = m_w + 1;
            nr = m_r; nn = m_nres;
            if (vcc_uv_i || !regen(m_mode)) begin nr = 0; nn = 0; end
            else if (m_r == RT) nn = 1;
            else if (tick_i) nr = m_r + 1;
            m_lwp   = (m_mode == 4) && (nm == 4) && (m_lwp || local_wake_i);
            m_wflag = (nm == 1) && ((m_mode == 1) ? m_wflag : wk);
            m_mode = nm; m_w = nw; m_r = nr; m_nres = nn;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic int exp_rxd();
        case (m_mode)
            1: return m_wflag ? 0 : 1;
            2: return int'(bus_i);
            3: return 1;
            default: return 0;
        endcase
    endfunction

    // Compare every output against the model in the middle of each cycle.
    always @(negedge clk) begin
        if (!done) begin
            check("R2 mode", int'(mode_o), m_mode);
            check("R10 reg_en", int'(reg_en_o), int'(regen(m_mode)));
            check("R10 xcvr_en", int'(xcvr_en_o), int'(m_mode == 2));
            check("R9 rxd", int'(rxd_o), exp_rxd());
            check("R7 nres", int'(nres_o), int'(m_nres));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Directed check at the next mid-cycle, with constant expectations.
    task automatic expect_at(string tag, int act_sel, int exp);
        int a;
        @(negedge clk);
        case (act_sel)
            0: a = int'(mode_o);
            1: a = int'(reg_en_o);
            2: a = int'(xcvr_en_o);
            3: a = int'(rxd_o);
            default: a = int'(nres_o);
        endcase
        check(tag, a, exp);
    endtask

    initial begin
        step(4);
        // R1: reset state
        expect_at("R1 mode", 0, 0); expect_at("R1 reg_en", 1, 0);
        expect_at("R1 rxd", 3, 0);  expect_at("R1 nres", 4, 0);
        rst_n = 1'b1; step(2);
        expect_at("R1 mode after reset", 0, 0);
        vs_hi_i = 1'b1; step(2);
        expect_at("R2 power-up to Fail-safe", 0, 1);
        expect_at("R10 reg on in Fail-safe", 1, 1);
        expect_at("R7 nres held", 4, 0);
        step(3 * RT + 10);
        expect_at("R7 nres released", 4, 1);
        en_i = 1'b1; step(2);
        expect_at("R3 Normal entered", 0, 2);
        expect_at("R10 xcvr on", 2, 1);
        bus_i = 1'b0; step(1);
        expect_at("R3 rxd follows dominant", 3, 0);
        bus_i = 1'b1; step(1);
        expect_at("R3 rxd follows recessive", 3, 1);
        txd_i = 1'b1; en_i = 1'b0; step(2);
        expect_at("R4 Silent on TXD high", 0, 3);
        expect_at("R9 rxd high in Silent", 3, 1);
        // R5: broken dominant bursts never wake
        bus_i = 1'b0; step(15); bus_i = 1'b1; step(1);
        bus_i = 1'b0; step(15); bus_i = 1'b1; step(2);
        expect_at("R5 glitches ignored", 0, 3);
        bus_i = 1'b0; step(3 * WT + 6);
        expect_at("R5 bus wake to Fail-safe", 0, 1);
        bus_i = 1'b1; step(2);
        expect_at("R9 rxd low after bus wake", 3, 0);
        en_i = 1'b1; step(3 * RT + 10);
        expect_at("R3 Normal again", 0, 2);
        txd_i = 1'b0; en_i = 1'b0; step(2);
        expect_at("R4 Sleep on TXD low", 0, 4);
        expect_at("R10 reg off in Sleep", 1, 0);
        expect_at("R9 rxd low in Sleep", 3, 0);
        expect_at("R7 nres low in Sleep", 4, 0);
        txd_i = 1'b1; en_i = 1'b1; step(6);
        expect_at("R6 EN alone keeps Sleep", 0, 4);
        en_i = 1'b0; step(2);
        local_wake_i = 1'b1; step(1); local_wake_i = 1'b0; step(3);
        expect_at("R6 still Sleep before EN", 0, 4);
        en_i = 1'b1; step(2);
        expect_at("R6 local wake then EN to Normal", 0, 2);
        step(3 * RT + 10);
        en_i = 1'b0; step(2);
        expect_at("R4 Silent again", 0, 3);
        vcc_uv_i = 1'b1; step(4);
        expect_at("R8 reset in Silent to Fail-safe", 0, 1);
        expect_at("R7 nres low on undervoltage", 4, 0);
        vcc_uv_i = 1'b0; step(3);
        vs_lo_i = 1'b1; vs_hi_i = 1'b0; step(2);
        expect_at("R2 supply drop to Unpowered", 0, 0);
        step(2);
        expect_at("R7 nres low when unpowered", 4, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        done = 1'b1;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule